// File: doc/BRIEF.md
# Configurable Pad Input/Output Cell

This block is one user-programmable I/O cell. It sits between a package pad and the core logic. Toward the core it returns two values. The first is the raw pad level. The second is a stored copy of that level, held either by an edge-triggered flip-flop or by a level-sensitive latch. Toward the pad it drives a data bit and an output enable. The data bit comes either straight from the core or from an output flip-flop, and both the data and the enable can be inverted. The cell also produces a weak pull-up request and a slew flag. The pad itself is modelled as three separate signals (in, out, enable) instead of a bidirectional wire.

Clocking comes from a group of clock lines that all cells on one die edge share. Each line has its own polarity bit. Each cell selects one of the lines. A polarity setting that makes the flip-flops capture on the line's rising edge also makes the latch transparent while that line is low, and the opposite polarity reverses both.

A single global clear, asynchronous and active high, empties both storage elements. The configuration vector and the line polarities are loaded only while the clear is high. They stay frozen after the clear is released.

Top module: `pad_io_cell`

## Requirements
- R1: `core_din` always equals `pad_i`.
- R2: When `cfg_i[0]` = 0 (flip-flop input mode), `core_din_reg` takes the value `pad_i` had at the last active edge of the selected line. The active edge is rising when that line's polarity bit is 0 and falling when it is 1.
- R3: When `cfg_i[0]` = 1 (latch input mode), `core_din_reg` follows `pad_i` while the selected line's effective level (line XOR its polarity bit) is 0, and holds its value while that level is 1.
- R4: `cfg_i[4]` selects the clock line (0 = `edge_clk[0]`, 1 = `edge_clk[1]`). Activity on the other line does not change any stored value.
- R5: The output flip-flop captures `core_dout` on the same active edge. `pad_o` equals the output source XOR `cfg_i[2]`, where the source is the output flip-flop when `cfg_i[1]` = 1 and `core_dout` when `cfg_i[1]` = 0.
- R6: `pad_oe` = `core_oe` XOR `cfg_i[3]`.
- R7: `pad_pull` = `cfg_i[5]` AND NOT `pad_oe`, so the pull-up is never requested while the driver is enabled.
- R8: While `gclr` is high, the input flip-flop, the input latch and the output flip-flop all read 0, whatever the clock lines are doing.
- R9: `cfg_i` and `line_inv_i` (bit n inverts `edge_clk[n]`) are captured only while `gclr` is high. Changes made after release have no effect.
- R10: `pad_slew` equals `cfg_i[6]` and affects nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclr | input | 1 | Global asynchronous clear, active high; also opens configuration capture |
| edge_clk | input | 2 | Clock lines shared along the die edge |
| cfg_i | input | 7 | Cell configuration: bit0 latch mode, bit1 registered output, bit2 data invert, bit3 enable invert, bit4 line select, bit5 pull-up, bit6 slew |
| line_inv_i | input | 2 | Polarity bit per clock line |
| pad_i | input | 1 | Level seen at the pad |
| core_dout | input | 1 | Output data from the core |
| core_oe | input | 1 | Output enable from the core, before inversion |
| pad_o | output | 1 | Data driven to the pad |
| pad_oe | output | 1 | Pad driver enable |
| pad_pull | output | 1 | Weak pull-up request |
| pad_slew | output | 1 | Slew-rate flag |
| core_din | output | 1 | Direct pad level to the core |
| core_din_reg | output | 1 | Stored pad level to the core |

## Verification
The bench sweeps all 128 cell configurations under all four polarity pairs. For each combination it runs the same eight-step pattern, in which both clock lines toggle at different rates. Pad data changes between edges, so flip-flop capture, latch tracking, and the choice of line and edge can each be told apart. The pad is resolved by a model in which a floating net reads 0 unless the pull-up is requested. This separates a correct pull-up from a missing one. It also includes steps where the cell drives its own pad, which exposes the path from the output register back into the input. After every clear is released, the configuration and polarity inputs are inverted, to show that they are not sampled again.

// File: rtl/pad_cell_pkg.sv
`timescale 1ns/1ps
package pad_cell_pkg;

    // number of clock lines shared along one die edge
    localparam int LINES = 2;
    localparam int SEL_W = (LINES > 1) ? $clog2(LINES) : 1;

    // static cell configuration; first member is the most significant bit
    typedef struct packed {
        logic             slew_fast;  // bit 6
        logic             pull_en;    // bit 5
        logic [SEL_W-1:0] line_sel;   // bit 4
        logic             oe_flip;    // bit 3
        logic             dout_flip;  // bit 2
        logic             dout_reg;   // bit 1
        logic             din_latch;  // bit 0
    } cell_cfg_t;

    localparam int CFG_W = $bits(cell_cfg_t);

endpackage

// File: rtl/pad_cell_cfg_hold.sv
`timescale 1ns/1ps
// Holds configuration and line polarity. Transparent only while the global
// clear is high, so the values are frozen for the whole working period.
module pad_cell_cfg_hold #(
    parameter int CW = 7,
    parameter int LW = 2
) (
    input  logic          gclr,
    input  logic [CW-1:0] cfg_i,
    input  logic [LW-1:0] inv_i,
    output logic [CW-1:0] cfg_q,
    output logic [LW-1:0] inv_q
);
    localparam int HW = CW + LW;

    logic [HW-1:0] hold_d;
    logic [HW-1:0] hold_q;

    always_comb begin
        hold_d = {inv_i, cfg_i};
    end

    always_latch begin
        if (gclr) hold_q <= hold_d;
    end

    assign cfg_q = hold_q[CW-1:0];
    assign inv_q = hold_q[HW-1:CW];
endmodule

// File: rtl/pad_cell_clk.sv
`timescale 1ns/1ps
// Picks one shared clock line and applies that line's polarity. A high
// effective clock means "capture on rising edge / latch closed".
module pad_cell_clk #(
    parameter int LINES = 2,
    parameter int SEL_W = 1
) (
    input  logic [LINES-1:0] lines,
    input  logic [LINES-1:0] inv,
    input  logic [SEL_W-1:0] sel,
    output logic             eff_clk
);
    logic [LINES-1:0] pol;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        assign pol[g] = lines[g] ^ inv[g];
    end

    assign eff_clk = pol[sel];
endmodule

// File: rtl/pad_cell_in.sv
`timescale 1ns/1ps
// Input storage: a flip-flop and a latch share the effective clock; the
// configured mode picks which one feeds the core.
module pad_cell_in (
    input  logic gclr,
    input  logic eff_clk,
    input  logic latch_mode,
    input  logic pad_i,
    output logic ff_q,
    output logic lat_q,
    output logic din_reg
);
    logic ff_d;
    logic lat_d;

    always_comb begin
        ff_d  = pad_i;
        lat_d = pad_i;
    end

    // edge storage, cleared asynchronously
    always_ff @(posedge eff_clk or posedge gclr) begin
        if (gclr) ff_q <= 1'b0;
        else      ff_q <= ff_d;
    end

    // level storage: open while the effective clock is low
    always_latch begin
        if (gclr)          lat_q <= 1'b0;
        else if (!eff_clk) lat_q <= lat_d;
    end

    assign din_reg = latch_mode ? lat_q : ff_q;
endmodule

// File: rtl/pad_cell_out.sv
`timescale 1ns/1ps
// Output side: data register, source mux, inversions and pull-up gating.
module pad_cell_out (
    input  logic gclr,
    input  logic eff_clk,
    input  logic dout_reg,
    input  logic dout_flip,
    input  logic oe_flip,
    input  logic pull_en,
    input  logic core_dout,
    input  logic core_oe,
    output logic of_q,
    output logic pad_o,
    output logic pad_oe,
    output logic pad_pull
);
    typedef struct packed {
        logic dreg;
    } out_state_t;

    out_state_t st_d;
    out_state_t st_q;

    always_comb begin
        st_d      = st_q;
        st_d.dreg = core_dout;
    end

    always_ff @(posedge eff_clk or posedge gclr) begin
        if (gclr) st_q <= '0;
        else      st_q <= st_d;
    end

    assign of_q = st_q.dreg;

    logic src;
    logic oe_eff;

    always_comb begin
        src      = dout_reg ? st_q.dreg : core_dout;
        oe_eff   = core_oe ^ oe_flip;
        pad_o    = src ^ dout_flip;
        pad_oe   = oe_eff;
        // pull-up only ever on an undriven pad
        pad_pull = pull_en & ~oe_eff;
    end
endmodule

// File: rtl/pad_io_cell.sv
`timescale 1ns/1ps
module pad_io_cell
    import pad_cell_pkg::*;
(
    input  logic                         gclr,
    input  logic [pad_cell_pkg::LINES-1:0] edge_clk,
    input  logic [pad_cell_pkg::CFG_W-1:0] cfg_i,
    input  logic [pad_cell_pkg::LINES-1:0] line_inv_i,
    input  logic                         pad_i,
    input  logic                         core_dout,
    input  logic                         core_oe,
    output logic                         pad_o,
    output logic                         pad_oe,
    output logic                         pad_pull,
    output logic                         pad_slew,
    output logic                         core_din,
    output logic                         core_din_reg
);
    logic [CFG_W-1:0] cfg_vec;
    logic [LINES-1:0] inv_q;
    cell_cfg_t        cfg_q;
    logic             eff_clk;
    logic             in_ff_q;
    logic             in_lat_q;
    logic             out_ff_q;

    pad_cell_cfg_hold #(.CW(CFG_W), .LW(LINES)) u_cfg (
        .gclr  (gclr),
        .cfg_i (cfg_i),
        .inv_i (line_inv_i),
        .cfg_q (cfg_vec),
        .inv_q (inv_q)
    );

    assign cfg_q = cell_cfg_t'(cfg_vec);

    pad_cell_clk #(.LINES(LINES), .SEL_W(SEL_W)) u_clk (
        .lines   (edge_clk),
        .inv     (inv_q),
        .sel     (cfg_q.line_sel),
        .eff_clk (eff_clk)
    );

    pad_cell_in u_in (
        .gclr       (gclr),
        .eff_clk    (eff_clk),
        .latch_mode (cfg_q.din_latch),
        .pad_i      (pad_i),
        .ff_q       (in_ff_q),
        .lat_q      (in_lat_q),
        .din_reg    (core_din_reg)
    );

    pad_cell_out u_out (
        .gclr      (gclr),
        .eff_clk   (eff_clk),
        .dout_reg  (cfg_q.dout_reg),
        .dout_flip (cfg_q.dout_flip),
        .oe_flip   (cfg_q.oe_flip),
        .pull_en   (cfg_q.pull_en),
        .core_dout (core_dout),
        .core_oe   (core_oe),
        .of_q      (out_ff_q),
        .pad_o     (pad_o),
        .pad_oe    (pad_oe),
        .pad_pull  (pad_pull)
    );

    assign core_din = pad_i;
    assign pad_slew = cfg_q.slew_fast;
endmodule

// File: rtl/pad_io_cell_chk.sv
`timescale 1ns/1ps
module pad_io_cell_chk (
    input logic gclr,
    input logic eff_clk,
    input logic pad_i,
    input logic core_dout,
    input logic in_ff_q,
    input logic in_lat_q,
    input logic out_ff_q,
    input logic pad_oe,
    input logic pad_pull
);
    // own record of the previous active edge since the last clear
    logic armed;
    logic prev_pad;
    logic prev_dout;

    always_ff @(posedge eff_clk or posedge gclr) begin
        if (gclr) begin
            armed     <= 1'b0;
            prev_pad  <= 1'b0;
            prev_dout <= 1'b0;
        end else begin
            armed     <= 1'b1;
            prev_pad  <= pad_i;
            prev_dout <= core_dout;
        end
    end

    // R2: input flop holds the pad level of the previous active edge
    p_in_capture_r2: assert property (@(posedge eff_clk) disable iff (gclr)
        armed |-> (in_ff_q == prev_pad));

    // R3: latch was transparent up to the closing edge
    p_latch_track_r3: assert property (@(posedge eff_clk) disable iff (gclr)
        in_lat_q == pad_i);

    // R5: output flop holds core data of the previous active edge
    p_out_capture_r5: assert property (@(posedge eff_clk) disable iff (gclr)
        armed |-> (out_ff_q == prev_dout));

    // R7: pull-up never requested while the driver is on
    p_pull_exclusive_r7: assert property (@(posedge eff_clk) disable iff (gclr)
        pad_oe |-> !pad_pull);
endmodule

bind pad_io_cell pad_io_cell_chk u_chk (
    .gclr      (gclr),
    .eff_clk   (eff_clk),
    .pad_i     (pad_i),
    .core_dout (core_dout),
    .in_ff_q   (in_ff_q),
    .in_lat_q  (in_lat_q),
    .out_ff_q  (out_ff_q),
    .pad_oe    (pad_oe),
    .pad_pull  (pad_pull)
);

// File: tb/pad_io_cell_test.sv
`timescale 1ns/1ps
module pad_io_cell_test;
    import pad_cell_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz, watchdog only

    logic             gclr;
    logic [1:0]       lines;
    logic [CFG_W-1:0] cfg_i;
    logic [1:0]       linv_i;
    logic             pad_net;
    logic             core_dout, core_oe;
    logic             pad_o, pad_oe, pad_pull, pad_slew, core_din, core_din_reg;
    logic             ext_en, ext_v;

    pad_io_cell uut (
        .gclr         (gclr),
        .edge_clk     (lines),
        .cfg_i        (cfg_i),
        .line_inv_i   (linv_i),
        .pad_i        (pad_net),
        .core_dout    (core_dout),
        .core_oe      (core_oe),
        .pad_o        (pad_o),
        .pad_oe       (pad_oe),
        .pad_pull     (pad_pull),
        .pad_slew     (pad_slew),
        .core_din     (core_din),
        .core_din_reg (core_din_reg)
    );

    // pad net: cell driver, else external driver, else pull-up or floating low
    always_comb pad_net = pad_oe ? pad_o : (ext_en ? ext_v : pad_pull);

    // reference model
    logic [6:0] m_cfg;
    logic [1:0] m_inv;
    logic       m_ff, m_lat, m_of;
    int         n_cmp = 0;
    int         n_bad = 0;
    int         cyc = 0;
    bit         done = 0;

    function automatic logic m_eff();
        int s = int'(m_cfg[4]);
        return lines[s] ^ m_inv[s];
    endfunction
    function automatic logic m_oe();
        return core_oe ^ m_cfg[3];
    endfunction
    function automatic logic m_do();
        return (m_cfg[1] ? m_of : core_dout) ^ m_cfg[2];
    endfunction
    function automatic logic m_pu();
        return m_cfg[5] & ~m_oe();
    endfunction
    function automatic logic m_pad();
        return m_oe() ? m_do() : (ext_en ? ext_v : m_pu());
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b cfg=%h inv=%b t=%0t",
                     tag, act, exp, m_cfg, m_inv, $time);
        end
    endtask

    task automatic chk_all(input string ph);
        chk({"R1 direct ", ph}, core_din, m_pad());
        if (m_cfg[0]) chk({"R3 latch ", ph}, core_din_reg, m_lat);
        else          chk({"R2 flop ", ph}, core_din_reg, m_ff);
        chk({"R5 dout ", ph}, pad_o, m_do());
        chk({"R6 oe ", ph}, pad_oe, m_oe());
        chk({"R7 pull ", ph}, pad_pull, m_pu());
        chk({"R10 slew ", ph}, pad_slew, m_cfg[6]);
    endtask

    task automatic step(input int k, input logic [6:0] c);
        logic old, pe, dv;
        logic [2:0] kb = 3'(k);
        ext_en    = kb[1];
        ext_v     = kb[0] ^ kb[1] ^ c[0];
        core_dout = kb[0] ^ kb[2] ^ c[1];
        core_oe   = kb[2] ^ c[2];
        #1;
        if (m_eff() == 1'b0) m_lat = m_pad();
        old = m_eff();
        pe  = m_pad();
        dv  = core_dout;
        // both lines move; only the selected one may matter (R4)
        lines = {kb[0] ^ kb[1], kb[0]};
        #1;
        if (!old && m_eff()) begin
            m_ff = pe;
            m_of = dv;
        end
        if (m_eff() == 1'b0) m_lat = m_pad();
        #1;
        chk_all("R4 step");
    endtask

    task automatic run_cfg(input logic [6:0] c, input logic [1:0] p);
        gclr      = 1'b1;
        cfg_i     = c;
        linv_i    = p;
        ext_en    = 1'b0;
        ext_v     = 1'b0;
        core_dout = c[0];
        core_oe   = 1'b0;
        #2;
        m_cfg = c; m_inv = p;
        m_ff = 1'b0; m_lat = 1'b0; m_of = 1'b0;
        chk("R8 cleared input", core_din_reg, 1'b0);
        chk_all("R8 clear");
        gclr = 1'b0;
        #1;
        if (m_eff() == 1'b0) m_lat = m_pad();
        #1;
        // later changes must be ignored
        cfg_i  = ~c;
        linv_i = ~p;
        #1;
        chk_all("R9 frozen");
        for (int k = 0; k < 8; k++) step(k, c);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            summary();
        end
    end

    initial begin
        gclr      = 1'b1;
        lines     = 2'b00;
        cfg_i     = '0;
        linv_i    = 2'b00;
        ext_en    = 1'b0;
        ext_v     = 1'b0;
        core_dout = 1'b0;
        core_oe   = 1'b0;
        #3;
        for (int p = 0; p < 4; p++)
            for (int c = 0; c < 128; c++)
                run_cfg(7'(c), 2'(p));
        summary();
    end
endmodule